// File: doc/BRIEF.md
# Addressed Nibble Latch I/O Port

This block models a small eight-bit trainer port made of two four-bit halves. Eight switch inputs feed two groups of drivers. Each group can place its four switch levels onto one shared four-bit bus. Eight display outputs are held by two nibble-wide holding stages. Each stage has its own control line. While that line is high the stage is open, and while it is low the stage keeps what it held. A one-bit address and a mode input decide which group drives the bus and which display nibble takes the bus value.

In select mode the address chooses which switch nibble is read, and the lower display nibble shows it. In route mode the lower switch nibble is always the one read, and the address chooses which display nibble stores it. The nibble that is not addressed keeps its last value. Inputs that the chosen wiring leaves unconnected take parameterised default levels. The default for a holding control is high, which makes the stage open. The default for a data input is low.

The holding stages are sampled on the clock. An open stage loads its data input at every rising edge. A closed stage does not change. Reset is asynchronous and active-low, and its release is synchronised to the clock.

Top module: `addr_nibble_port`

## Requirements
- R1: While reset is asserted, all eight display outputs read 0.
- R2: A display nibble whose control is high loads its data input at every rising clock edge. Its output shows that value from the edge onward.
- R3: A display nibble whose control is low keeps its value across edges, whatever its data input does.
- R4: Switch levels pass through without inversion: 1 means an open switch and 0 a closed one. The level reaches the bus and the display bit for bit.
- R5: In select mode (mode=0) with address 0, grp_oe reads 01 (bit 0 is the lower switch group). bus_o equals sw[3:0], and led[3:0] takes that value at the next edge.
- R6: In select mode with address 1, grp_oe reads 10. bus_o equals sw[7:4], and led[3:0] takes that value at the next edge.
- R7: In select mode the upper display control is unconnected and defaults high. Its data is unconnected and defaults to 0, so led[7:4] reads 0 after the next edge.
- R8: In route mode (mode=1) only the lower switch group drives. grp_oe reads 01 and bus_o equals sw[3:0].
- R9: In route mode with address 0, led[3:0] takes bus_o at the next edge and led[7:4] holds.
- R10: In route mode with address 1, led[7:4] takes bus_o at the next edge and led[3:0] holds.
- R11: The two grp_oe bits are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 1 | 0 = select mode, 1 = route mode |
| addr | input | 1 | Nibble address |
| sw | input | 8 | Switch levels, 1 = open, 0 = closed |
| led | output | 8 | Display nibbles, upper and lower |
| bus_o | output | 4 | Value on the shared switch bus |
| grp_oe | output | 2 | Driver enable per switch group, bit 0 = lower |

## Verification
The bench changes the switches while a display nibble is closed. A stage that leaked its data input would show the new switch value instead of holding.

It flips the route address back and forth with fresh switch values each time. A decoder that opened both stages, or that cleared the unaddressed one, would lose the retained nibble.

It also checks in both modes that only one group's enable is set. A decoder that left both enables on would show a merged bus value and a two-bit grp_oe.

Select mode is entered after route mode has filled the upper nibble. The bench confirms that the upper nibble falls to its default of 0, and that the polarity of distinct switch patterns survives end to end.

// File: rtl/anp_pkg.sv
package anp_pkg;
  typedef enum logic {
    PM_SELECT = 1'b0,
    PM_ROUTE  = 1'b1
  } port_mode_e;
endpackage

// File: rtl/anp_rst_sync.sv
module anp_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_r;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_r <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_r <= 1'b1;
      srst_n <= meta_r;
    end
  end
endmodule

// File: rtl/anp_pin_default.sv
module anp_pin_default #(
  parameter int          W   = 1,
  parameter logic [W-1:0] DEF = '0
) (
  input  logic         conn,
  input  logic [W-1:0] val,
  output logic [W-1:0] y
);
  always_comb begin
    y = conn ? val : DEF;
  end
endmodule

// File: rtl/anp_grp_drv.sv
module anp_grp_drv #(
  parameter int W = 4
) (
  input  logic         en,
  input  logic [W-1:0] sw,
  output logic         oe,
  output logic [W-1:0] dout
);
  logic en_n;

  always_comb begin
    en_n = ~en;
    oe   = ~en_n;
    dout = en_n ? '0 : sw;
  end
endmodule

// File: rtl/anp_nib_latch.sv
module anp_nib_latch #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctl,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (ctl) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q = q_r;

  AST_LATCH_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ctl |=> (q == $past(d)));                                  // R2
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl |=> (q == $past(q)));                                 // R3
endmodule

// File: rtl/addr_nibble_port.sv
module addr_nibble_port #(
  parameter int   NIB_W   = 4,
  parameter logic CTL_DEF = 1'b1,
  parameter logic DIN_DEF = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode,
  input  logic                 addr,
  input  logic [2*NIB_W-1:0]   sw,
  output logic [2*NIB_W-1:0]   led,
  output logic [NIB_W-1:0]     bus_o,
  output logic [1:0]           grp_oe
);
  import anp_pkg::*;

  localparam int GRPS   = 2;
  localparam int PORT_W = GRPS * NIB_W;
  localparam logic [NIB_W-1:0] D_DEF_VEC = {NIB_W{DIN_DEF}};

  logic             srst_n;
  port_mode_e       mode_e;
  logic [GRPS-1:0]  grp_en;
  logic [GRPS-1:0]  ctl_val;
  logic [GRPS-1:0]  ctl_conn;
  logic [GRPS-1:0]  din_conn;
  logic [GRPS-1:0]  drv_oe;
  logic [NIB_W-1:0] drv_dat [GRPS];
  logic [NIB_W-1:0] bus;

  anp_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  // address decode: which group drives, which display stage opens
  always_comb begin
    mode_e   = port_mode_e'(mode);
    grp_en   = '0;
    ctl_val  = '0;
    ctl_conn = '0;
    din_conn = '0;
    if (mode_e == PM_SELECT) begin
      grp_en      = {addr, ~addr};
      ctl_val[0]  = 1'b1;
      ctl_conn[0] = 1'b1;
      din_conn[0] = 1'b1;
    end else begin
      grp_en      = 2'b01;
      ctl_val     = {addr, ~addr};
      ctl_conn    = 2'b11;
      din_conn    = 2'b11;
    end
  end

  for (genvar g = 0; g < GRPS; g++) begin : g_drv
    anp_grp_drv #(.W(NIB_W)) u_drv (
      .en   (grp_en[g]),
      .sw   (sw[g*NIB_W +: NIB_W]),
      .oe   (drv_oe[g]),
      .dout (drv_dat[g])
    );
  end

  // shared bus: disabled drivers contribute zero
  always_comb begin
    bus = '0;
    for (int g = 0; g < GRPS; g++) begin
      if (drv_oe[g]) bus = bus | drv_dat[g];
    end
  end

  for (genvar g = 0; g < GRPS; g++) begin : g_disp
    logic             ctl_eff;
    logic [NIB_W-1:0] din_eff;

    anp_pin_default #(.W(1), .DEF(CTL_DEF)) u_ctl_def (
      .conn (ctl_conn[g]),
      .val  (ctl_val[g]),
      .y    (ctl_eff)
    );
    anp_pin_default #(.W(NIB_W), .DEF(D_DEF_VEC)) u_din_def (
      .conn (din_conn[g]),
      .val  (bus),
      .y    (din_eff)
    );
    anp_nib_latch #(.W(NIB_W)) u_lat (
      .clk   (clk),
      .rst_n (srst_n),
      .ctl   (ctl_eff),
      .d     (din_eff),
      .q     (led[g*NIB_W +: NIB_W])
    );
  end

  assign bus_o  = bus;
  assign grp_oe = drv_oe;

  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0(grp_oe));                                                   // R11
  AST_SEL_UPPER_SRC: assert property (@(posedge clk) disable iff (!srst_n)
    (mode == 1'b0 && addr) |-> (bus_o == sw[PORT_W-1 -: NIB_W]));        // R6
  AST_ROUTE_LOWER_ONLY: assert property (@(posedge clk) disable iff (!srst_n)
    (mode == 1'b1) |-> (grp_oe == 2'b01 && bus_o == sw[NIB_W-1:0]));     // R8
  AST_SEL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!srst_n)
    (mode == 1'b0) |=> (led[PORT_W-1 -: NIB_W] == D_DEF_VEC));           // R7
endmodule

// File: tb/tb_addr_nibble_port.sv
`timescale 1ns/1ps
module tb_addr_nibble_port;
  logic       clk;
  logic       rst_n;
  logic       mode;
  logic       addr;
  logic [7:0] sw;
  logic [7:0] led;
  logic [3:0] bus_o;
  logic [1:0] grp_oe;

  int total = 0;
  int bad   = 0;

  logic [13:0] exp_q [$];
  string       tag_q [$];
  logic [3:0]  m_lo;
  logic [3:0]  m_hi;

  addr_nibble_port dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (mode),
    .addr   (addr),
    .sw     (sw),
    .led    (led),
    .bus_o  (bus_o),
    .grp_oe (grp_oe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // driver: apply inputs at negedge, push expected result of the next edge
  task automatic step(input logic m, input logic a, input logic [7:0] s, input string tag);
    logic [3:0] b;
    logic [1:0] oe;
    @(negedge clk);
    mode = m;
    addr = a;
    sw   = s;
    if (!m) begin
      oe   = a ? 2'b10 : 2'b01;
      b    = a ? s[7:4] : s[3:0];
      m_lo = b;
      m_hi = 4'h0;
    end else begin
      oe = 2'b01;
      b  = s[3:0];
      if (!a) m_lo = b;
      else    m_hi = b;
    end
    exp_q.push_back({m_hi, m_lo, b, oe});
    tag_q.push_back(tag);
  endtask

  // monitor: compare after each rising edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [13:0] e;
      string       t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if ({led, bus_o, grp_oe} !== e) begin
        bad++;
        $display("FAIL %s led/bus/oe got=%h exp=%h", t, {led, bus_o, grp_oe}, e);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    mode  = 1'b0;
    addr  = 1'b0;
    sw    = 8'h00;
    m_lo  = 4'h0;
    m_hi  = 4'h0;
    repeat (3) @(posedge clk);
    #1;
    total++;
    if (led !== 8'h00) begin
      bad++;
      $display("FAIL R1 reset led got=%h exp=00", led);
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // select mode, both addresses, polarity patterns
    step(1'b0, 1'b0, 8'hA5, "R5 select a0");
    step(1'b0, 1'b0, 8'h3C, "R5 R2 select a0 reload");
    step(1'b0, 1'b1, 8'hA5, "R6 select a1");
    step(1'b0, 1'b1, 8'hF0, "R6 R4 select a1 open");
    step(1'b0, 1'b0, 8'hFF, "R4 all open");
    step(1'b0, 1'b0, 8'h00, "R4 all closed");
    step(1'b0, 1'b1, 8'h6E, "R7 upper default zero");

    // route mode: fill both nibbles
    step(1'b1, 1'b0, 8'h07, "R9 route a0");
    step(1'b1, 1'b1, 8'hB9, "R10 route a1");
    // hold while closed: lower keeps 7 as switches move
    step(1'b1, 1'b1, 8'h0C, "R3 R10 lower holds");
    step(1'b1, 1'b1, 8'hF3, "R3 R8 lower holds");
    step(1'b1, 1'b0, 8'h02, "R9 R3 upper retained");
    step(1'b1, 1'b0, 8'h5D, "R9 upper retained");

    // alternate addresses with fresh data
    for (int i = 0; i < 16; i++) begin
      logic [7:0] v;
      v = 8'(i * 37 + 11);
      step(1'b1, 1'(i % 2), v, (i % 2) ? "R10 R11 toggle" : "R9 R11 toggle");
    end

    // back to select: upper falls to default
    step(1'b0, 1'b1, 8'h9A, "R7 R6 upper cleared");
    step(1'b0, 1'b0, 8'h9A, "R7 R5 lower switch read");

    repeat (3) @(posedge clk);
    #1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule